// File: doc/BRIEF.md
# Dual-Clock Host Register Bridge

This block joins a host bus clock domain to a faster user-logic clock domain through a register space of `NUM_REGS` words of `REG_W` bits (32 words of 64 bits by default). For host writes, the block captures a per-byte strobe vector and a data word in the host domain. It then announces the write to the user domain as a one-cycle strobe pulse. The data word never crosses on its own: it is held steady in the host domain and read by user logic while the pulse is present. A busy flag tells the host to wait until the user side has acknowledged the write.

For reads, the block copies the full readback image (`NUM_REGS*REG_W` bits) from the user domain into the host domain again and again, with no request from the host. A user-side holding register is loaded on a request toggle. The host-side copy is loaded only after the matching done toggle has crossed back, so the host always sees a whole image taken at one instant. After each refresh, the host side waits `SNAP_GAP` host cycles before it requests the next snapshot.

Top module: `hostreg_bridge`

## Requirements
- R1: While reset is applied and in the first host cycle after it, `h_busy` is 0, `u_wr_strb` is all zero and `h_rd_image` is all zero.
- R2: A host cycle with `h_wr_en`=1 and `h_busy`=0 accepts the write, and `h_busy` reads 1 in the next host cycle.
- R3: Each accepted write produces exactly one user-clock cycle in which `u_wr_strb` equals the captured strobe vector. In every other cycle, `u_wr_strb` is zero.
- R4: `u_wr_data` shows the data word of the last accepted write and stays unchanged while `h_busy` is 1.
- R5: `h_busy` returns to 0 only after the user-side pulse for that write has been produced.
- R6: A write request made while `h_busy` is 1 is ignored: it produces no pulse and changes neither the captured strobes nor the data.
- R7: Strobe bit index = register index × 8 + byte lane. Byte lane 0 covers data bits 7:0, and lane k covers bits 8k+7:8k.
- R8: `h_rd_image` is refreshed from `u_rd_image` repeatedly without any host request, so a change at the user side appears at the host side within a bounded time.
- R9: Every value of `h_rd_image` equals one value that `u_rd_image` held at a single user clock edge. The value stays constant between refreshes and for at least `SNAP_GAP` host cycles after each refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| hrst | input | 1 | Host-domain synchronous reset, active high |
| h_wr_en | input | 1 | Host write transfer request |
| h_wr_strb | input | NUM_REGS*REG_W/8 | Per-byte write strobes, index = reg*8 + lane |
| h_wr_data | input | REG_W | Write data word |
| h_busy | output | 1 | Write crossing in progress; host must wait |
| h_rd_image | output | NUM_REGS*REG_W | Host-domain copy of the readback image |
| uclk | input | 1 | User-logic clock (faster than hclk) |
| urst | input | 1 | User-domain synchronous reset, active high |
| u_wr_strb | output | NUM_REGS*REG_W/8 | One-cycle strobe pulse per accepted write |
| u_wr_data | output | REG_W | Captured write data, steady around the pulse |
| u_rd_image | input | NUM_REGS*REG_W | User-domain readback image |

## Verification
The assertions assume that `uclk` is faster than `hclk`, so a toggle crosses and is answered before the host can issue another one. They also assume that both resets overlap in time, so the toggle pairs start equal. The bench runs the user clock at roughly three times the host rate and holds both resets together. It applies write requests only on falling host edges, and it writes only non-zero strobe vectors so that every pulse can be seen. To test tearing, the readback image changes on every user cycle, with every word carrying the same counter. Any mix of two instants then shows up as unequal words.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

    // Width of one byte lane inside a register word.
    localparam int unsigned LANE_W = 8;

    // Host-side snapshot sequencer states.
    typedef enum logic {
        SNAP_IDLE = 1'b0,   // counting down the spacing gap
        SNAP_WAIT = 1'b1    // request toggled, waiting for done toggle
    } snap_st_e;

endpackage

// File: rtl/hrb_sync2.sv
module hrb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/hrb_wr_cross.sv
module hrb_wr_cross #(
    parameter int STB_W  = 256,
    parameter int DATA_W = 64
) (
    input  logic              hclk,
    input  logic              hrst,
    input  logic              h_wr_en,
    input  logic [STB_W-1:0]  h_wr_strb,
    input  logic [DATA_W-1:0] h_wr_data,
    output logic              h_busy,
    input  logic              uclk,
    input  logic              urst,
    output logic [STB_W-1:0]  u_wr_strb,
    output logic [DATA_W-1:0] u_wr_data
);

    // ---------------- host side ----------------
    typedef struct packed {
        logic              req;
        logic [STB_W-1:0]  strb;
        logic [DATA_W-1:0] data;
    } host_t;

    host_t hs_d, hs_q;
    logic  ack_sync;
    logic  accept;

    assign h_busy = hs_q.req ^ ack_sync;
    assign accept = h_wr_en && !h_busy;

    always_comb begin
        hs_d = hs_q;
        if (accept) begin
            hs_d.req  = ~hs_q.req;
            hs_d.strb = h_wr_strb;
            hs_d.data = h_wr_data;
        end
    end

    always_ff @(posedge hclk) begin
        if (hrst) hs_q <= '0;
        else      hs_q <= hs_d;
    end

    // ---------------- user side ----------------
    typedef struct packed {
        logic             seen;
        logic [STB_W-1:0] pulse;
    } user_t;

    user_t us_d, us_q;
    logic  req_sync;
    logic  req_edge;

    hrb_sync2 #(.W(1)) u_req_sync (
        .clk (uclk),
        .rst (urst),
        .d   (hs_q.req),
        .q   (req_sync)
    );

    assign req_edge = req_sync ^ us_q.seen;

    always_comb begin
        us_d       = us_q;
        us_d.seen  = req_sync;
        us_d.pulse = req_edge ? hs_q.strb : '0;
    end

    always_ff @(posedge uclk) begin
        if (urst) us_q <= '0;
        else      us_q <= us_d;
    end

    hrb_sync2 #(.W(1)) u_ack_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (us_q.seen),
        .q   (ack_sync)
    );

    assign u_wr_strb = us_q.pulse;
    assign u_wr_data = hs_q.data;

    // ---------------- assertions ----------------
    assert_busy_rise_R2: assert property (@(posedge hclk) disable iff (hrst)
        (h_wr_en && !h_busy) |=> h_busy);

    assert_data_steady_R4: assert property (@(posedge hclk) disable iff (hrst)
        h_busy |=> $stable(u_wr_data));

    assert_busy_until_ack_R5: assert property (@(posedge hclk) disable iff (hrst)
        h_busy |=> (h_busy || !$stable(ack_sync)));

    assert_ignore_busy_R6: assert property (@(posedge hclk) disable iff (hrst)
        (h_busy && h_wr_en) |=> ($stable(hs_q.strb) && $stable(hs_q.req)));

    assert_single_pulse_R3: assert property (@(posedge uclk) disable iff (urst)
        (u_wr_strb != '0) |=> (u_wr_strb == '0));

endmodule

// File: rtl/hrb_rd_snap.sv
module hrb_rd_snap
    import hrb_pkg::*;
#(
    parameter int IMG_W = 2048,
    parameter int GAP   = 4
) (
    input  logic             hclk,
    input  logic             hrst,
    output logic [IMG_W-1:0] h_img,
    input  logic             uclk,
    input  logic             urst,
    input  logic [IMG_W-1:0] u_img
);

    localparam int GAP_W = (GAP < 1) ? 1 : $clog2(GAP + 1);

    // ---------------- host side ----------------
    typedef struct packed {
        snap_st_e         st;
        logic             req;
        logic [GAP_W-1:0] gap;
        logic [IMG_W-1:0] img;
    } host_t;

    host_t            hs_d, hs_q;
    logic             done_sync;
    logic [IMG_W-1:0] hold;

    always_comb begin
        hs_d = hs_q;
        case (hs_q.st)
            SNAP_IDLE: begin
                if (hs_q.gap == '0) begin
                    hs_d.req = ~hs_q.req;
                    hs_d.st  = SNAP_WAIT;
                end else begin
                    hs_d.gap = hs_q.gap - 1'b1;
                end
            end
            SNAP_WAIT: begin
                if (done_sync == hs_q.req) begin
                    hs_d.img = hold;
                    hs_d.gap = GAP_W'(GAP);
                    hs_d.st  = SNAP_IDLE;
                end
            end
            default: hs_d.st = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge hclk) begin
        if (hrst) hs_q <= '0;
        else      hs_q <= hs_d;
    end

    assign h_img = hs_q.img;

    // ---------------- user side ----------------
    typedef struct packed {
        logic             seen;
        logic [IMG_W-1:0] hold;
    } user_t;

    user_t us_d, us_q;
    logic  req_sync;

    hrb_sync2 #(.W(1)) u_req_sync (
        .clk (uclk),
        .rst (urst),
        .d   (hs_q.req),
        .q   (req_sync)
    );

    always_comb begin
        us_d      = us_q;
        us_d.seen = req_sync;
        if (req_sync != us_q.seen) us_d.hold = u_img;
    end

    always_ff @(posedge uclk) begin
        if (urst) us_q <= '0;
        else      us_q <= us_d;
    end

    assign hold = us_q.hold;

    hrb_sync2 #(.W(1)) u_done_sync (
        .clk (hclk),
        .rst (hrst),
        .d   (us_q.seen),
        .q   (done_sync)
    );

    // ---------------- assertions ----------------
    assert_frozen_wait_R9: assert property (@(posedge hclk) disable iff (hrst)
        (hs_q.st == SNAP_WAIT && done_sync != hs_q.req) |=> $stable(h_img));

    assert_gap_steady_R9: assert property (@(posedge hclk) disable iff (hrst)
        (hs_q.st == SNAP_IDLE) |=> $stable(h_img));

    assert_hold_steady_R9: assert property (@(posedge uclk) disable iff (urst)
        (req_sync == us_q.seen) |=> $stable(us_q.hold));

    assert_wait_leaves_R8: assert property (@(posedge hclk) disable iff (hrst)
        (hs_q.st == SNAP_IDLE && hs_q.gap == '0) |=> (hs_q.st == SNAP_WAIT));

endmodule

// File: rtl/hostreg_bridge.sv
module hostreg_bridge
    import hrb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 64,
    parameter int SNAP_GAP = 4
) (
    input  logic                             hclk,
    input  logic                             hrst,
    input  logic                             h_wr_en,
    input  logic [NUM_REGS*REG_W/LANE_W-1:0] h_wr_strb,
    input  logic [REG_W-1:0]                 h_wr_data,
    output logic                             h_busy,
    output logic [NUM_REGS*REG_W-1:0]        h_rd_image,
    input  logic                             uclk,
    input  logic                             urst,
    output logic [NUM_REGS*REG_W/LANE_W-1:0] u_wr_strb,
    output logic [REG_W-1:0]                 u_wr_data,
    input  logic [NUM_REGS*REG_W-1:0]        u_rd_image
);

    localparam int STB_W = NUM_REGS * REG_W / LANE_W;
    localparam int IMG_W = NUM_REGS * REG_W;

    hrb_wr_cross #(
        .STB_W  (STB_W),
        .DATA_W (REG_W)
    ) u_wr_cross (
        .hclk      (hclk),
        .hrst      (hrst),
        .h_wr_en   (h_wr_en),
        .h_wr_strb (h_wr_strb),
        .h_wr_data (h_wr_data),
        .h_busy    (h_busy),
        .uclk      (uclk),
        .urst      (urst),
        .u_wr_strb (u_wr_strb),
        .u_wr_data (u_wr_data)
    );

    hrb_rd_snap #(
        .IMG_W (IMG_W),
        .GAP   (SNAP_GAP)
    ) u_rd_snap (
        .hclk  (hclk),
        .hrst  (hrst),
        .h_img (h_rd_image),
        .uclk  (uclk),
        .urst  (urst),
        .u_img (u_rd_image)
    );

endmodule

// File: tb/hostreg_bridge_bench.sv
module hostreg_bridge_bench;

    localparam int  HCLK_PERIOD = 20;
    localparam int  UCLK_PERIOD = 6;
    localparam int  NREG  = 32;
    localparam int  RW    = 64;
    localparam int  SW    = NREG * RW / 8;
    localparam int  IW    = NREG * RW;

    logic          hclk = 0, uclk = 0;
    logic          hrst = 1, urst = 1;
    logic          h_wr_en = 0;
    logic [SW-1:0] h_wr_strb = '0;
    logic [RW-1:0] h_wr_data = '0;
    logic          h_busy;
    logic [IW-1:0] h_rd_image;
    logic [SW-1:0] u_wr_strb;
    logic [RW-1:0] u_wr_data;
    logic [IW-1:0] u_rd_image = '0;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(HCLK_PERIOD/2) hclk = ~hclk;
    always #(UCLK_PERIOD/2) uclk = ~uclk;

    hostreg_bridge u_hostreg_bridge (
        .hclk (hclk), .hrst (hrst), .h_wr_en (h_wr_en),
        .h_wr_strb (h_wr_strb), .h_wr_data (h_wr_data), .h_busy (h_busy),
        .h_rd_image (h_rd_image), .uclk (uclk), .urst (urst),
        .u_wr_strb (u_wr_strb), .u_wr_data (u_wr_data), .u_rd_image (u_rd_image)
    );

    // user-side image source
    bit            spin = 0;
    logic [RW-1:0] spin_ctr = '0;
    logic [IW-1:0] fixed_pat = {NREG{64'hC3C3_0F0F_5A5A_9696}};
    always @(negedge uclk) begin
        if (spin) begin
            spin_ctr   <= spin_ctr + 1;
            u_rd_image <= {NREG{spin_ctr + 64'd1}};
        end else begin
            u_rd_image <= fixed_pat;
        end
    end

    // user-side pulse monitor
    int            pulse_cnt = 0;
    logic [SW-1:0] last_strb = '0;
    logic [RW-1:0] last_data = '0;
    always @(negedge uclk) begin
        if (!urst && u_wr_strb != '0) begin
            pulse_cnt++;
            last_strb = u_wr_strb;
            last_data = u_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [SW-1:0] s, input logic [RW-1:0] d);
        @(negedge hclk);
        h_wr_en = 1; h_wr_strb = s; h_wr_data = d;
        @(negedge hclk);
        h_wr_en = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (h_busy && n < 60) begin @(negedge hclk); n++; end
    endtask

    task automatic t_reset;
        repeat (5) @(negedge hclk);
        chk(h_busy == 0 && u_wr_strb == '0 && h_rd_image == '0, "R1 reset",
            {h_busy, u_wr_strb[SW-2:0]}, '0);
        hrst = 0; urst = 0;
        @(negedge hclk);
        chk(h_busy == 0, "R1 busy after reset", SW'(h_busy), '0);
        chk(h_rd_image == '0, "R1 image after reset", h_rd_image[SW-1:0], '0);
    endtask

    task automatic t_single_write;
        int base, n;
        logic [SW-1:0] s = {64'h1, 64'h0, 64'h8000_0000_0000_0000, 64'hF0};
        base = pulse_cnt;
        host_write(s, 64'hDEAD_BEEF_0123_4567);
        chk(h_busy == 1, "R2 busy rises", SW'(h_busy), SW'(1));
        wait_idle(n);
        chk(n < 60, "R5 busy clears", SW'(n), SW'(0));
        chk(pulse_cnt - base == 1, "R5 pulse before busy clear",
            SW'(pulse_cnt - base), SW'(1));
        chk(last_strb == s, "R3 strobe pattern", last_strb, s);
        chk(last_data == 64'hDEAD_BEEF_0123_4567, "R4 data presented",
            SW'(last_data), SW'(64'hDEAD_BEEF_0123_4567));
        repeat (4) @(negedge hclk);
        chk(pulse_cnt - base == 1, "R3 single pulse", SW'(pulse_cnt - base), SW'(1));
    endtask

    task automatic t_busy_ignore;
        int base, n;
        base = pulse_cnt;
        host_write(SW'(64'h0F), 64'h1111);
        chk(h_busy == 1, "R2 busy for ignore test", SW'(h_busy), SW'(1));
        h_wr_en = 1; h_wr_strb = SW'(64'hF000); h_wr_data = 64'h2222;
        @(negedge hclk);
        h_wr_en = 0;
        wait_idle(n);
        repeat (6) @(negedge hclk);
        chk(pulse_cnt - base == 1, "R6 no extra pulse", SW'(pulse_cnt - base), SW'(1));
        chk(last_strb == SW'(64'h0F), "R6 strobes kept", last_strb, SW'(64'h0F));
        chk(u_wr_data == 64'h1111, "R6 data kept", SW'(u_wr_data), SW'(64'h1111));
    endtask

    task automatic t_lane_map;
        int n;
        logic [SW-1:0] s;
        s = '0; s[3*8+2] = 1'b1;
        host_write(s, 64'h0000_0000_00AB_0000);
        wait_idle(n);
        chk(last_strb == s, "R7 reg3 lane2 bit 26", last_strb, s);
        chk(last_data[23:16] == 8'hAB, "R7 lane2 data bits", SW'(last_data[23:16]), SW'(8'hAB));
        s = '0; s[31*8+7] = 1'b1;
        host_write(s, 64'hCD00_0000_0000_0000);
        wait_idle(n);
        chk(last_strb == s, "R7 reg31 lane7 bit 255", last_strb, s);
        chk(last_data[63:56] == 8'hCD, "R7 lane7 data bits", SW'(last_data[63:56]), SW'(8'hCD));
    endtask

    task automatic t_back_to_back;
        int base, n;
        base = pulse_cnt;
        for (int k = 1; k <= 3; k++) begin
            host_write(SW'(k), RW'(k * 3));
            wait_idle(n);
        end
        chk(pulse_cnt - base == 3, "R3 three pulses", SW'(pulse_cnt - base), SW'(3));
        chk(last_strb == SW'(3), "R3 last pattern", last_strb, SW'(3));
    endtask

    task automatic t_readback;
        fixed_pat = {NREG{64'h0123_4567_89AB_CDEF}};
        fixed_pat[IW-1 -: RW] = 64'hFEED_FACE_CAFE_F00D;
        repeat (60) @(negedge hclk);
        chk(h_rd_image[RW-1:0] == 64'h0123_4567_89AB_CDEF, "R8 word0",
            SW'(h_rd_image[RW-1:0]), SW'(64'h0123_4567_89AB_CDEF));
        chk(h_rd_image[IW-1 -: RW] == 64'hFEED_FACE_CAFE_F00D, "R8 word31",
            SW'(h_rd_image[IW-1 -: RW]), SW'(64'hFEED_FACE_CAFE_F00D));
        fixed_pat = {NREG{64'h7777_0000_7777_0000}};
        repeat (60) @(negedge hclk);
        chk(h_rd_image == {NREG{64'h7777_0000_7777_0000}}, "R8 auto refresh",
            h_rd_image[SW-1:0], {4{64'h7777_0000_7777_0000}});
    endtask

    task automatic t_no_tear;
        int torn = 0, changes = 0, short_gap = 0, since = 100;
        logic [RW-1:0] prev_w, w0;
        spin = 1;
        repeat (20) @(negedge hclk);
        prev_w = h_rd_image[RW-1:0];
        for (int c = 0; c < 400; c++) begin
            @(negedge hclk);
            w0 = h_rd_image[RW-1:0];
            for (int r = 1; r < NREG; r++)
                if (h_rd_image[r*RW +: RW] != w0) torn++;
            since++;
            if (w0 != prev_w) begin
                changes++;
                if (since < 5) short_gap++;
                since = 0;
            end
            prev_w = w0;
        end
        spin = 0;
        chk(torn == 0, "R9 no torn image", SW'(torn), '0);
        chk(short_gap == 0, "R9 refresh spacing", SW'(short_gap), '0);
        chk(changes >= 10, "R8 repeated refresh", SW'(changes), SW'(10));
    endtask

    initial begin
        t_reset();
        t_single_write();
        t_busy_ignore();
        t_lane_map();
        t_back_to_back();
        t_readback();
        t_no_tear();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(HCLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule